// File: doc/BRIEF.md
# Scanline Timing and Video Interrupt Generator

This block derives display timing from the CPU clock. A cycle counter divides the clock into scanlines of a fixed length, and a line counter steps through the lines of a frame and returns to line 0 after the last one. Software reads the current line number directly from an output port.

Four interrupt sources are each tied to a fixed bit position:
- bit 4: the current line reaches a programmable compare value.
- bit 5: the line counter wraps back to 0.
- bit 6: the visible part of the frame ends.
- bit 7: a request from an external line-rate timer.

An event is latched into the status register only while its enable bit is set. Software clears a latched bit by writing a 1 to it. The request output stays high while any enabled status bit is set. The vector output points at the highest-numbered pending source, computed as the programmed base plus the bit number, times four.

A single write port reaches four registers through a 2-bit select: line compare, enable, status clear and vector base. The block is meant to sit between the CPU clock domain and the CPU interrupt input. Tile rendering, palettes and the CPU itself are outside it.

Top module: `line_irq_gen`

## Requirements
- R1: After reset, line_o is 0, stat_o is 0, irq_o is 0 and vec_o is 0.
- R2: line_o advances by one after every CYC_PER_LINE clock cycles following reset. It takes the values 0 to LINES-1 and goes from LINES-1 back to 0.
- R3: When line_o advances to VIS_LINES, a frame-done event occurs on bit 6.
- R4: When line_o advances from LINES-1 to 0, a wrap event occurs on bit 5. Reset itself produces no wrap event.
- R5: When line_o advances to a value equal to the compare register, a match event occurs on bit 4. Writing a compare value equal to the current line does not produce an event until the line next advances to that value.
- R6: timer_req_i sampled high at a clock edge is an event on bit 7.
- R7: An event sets its status bit at the same edge where line_o changes (or where timer_req_i is sampled), and only if that enable bit was already set before the edge. An event whose enable bit is clear leaves stat_o unchanged.
- R8: A status-clear write clears every status bit written as 1 and leaves the other bits alone. If an event sets a bit at the same edge that the bit is cleared, the bit ends up set.
- R9: irq_o is 1 exactly when some bit is set in both stat_o and the enable register. Clearing an enable bit masks its pending status without clearing it.
- R10: While irq_o is 1, vec_o equals {(base + k) mod 256, 2'b00}, where k is the highest bit set in both status and enable. While irq_o is 0, vec_o is 0.
- R11: wr_sel_i selects the target register: 0 = line compare, 1 = enable, 2 = status clear, 3 = vector base. A write takes effect at the clock edge where wr_en_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (see R11) |
| wr_data_i | input | 8 | Write data |
| timer_req_i | input | 1 | Line-rate timer request (bit 7 source) |
| line_o | output | LW | Current line number |
| stat_o | output | 8 | Interrupt status register |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 10 | Interrupt vector address |

## Verification
The bench runs a reduced geometry (8 cycles per line, 12 lines, frame done at line 9), so whole frames are short enough to sweep. It sweeps the compare value over every line. A design that compared against the current line instead of the next one would fire one line late, and one that fired on a compare write would set bit 4 in the middle of a line.

A long mixed run covers several overlapping cases:
- Timer pulses, status clears and enable toggles all overlap, including a clear and a set on the same edge. A design that let the clear win would drop a pending bit.
- The enable register is masked while a bit is pending. A design that cleared status on mask would lose that interrupt.
- A vector base near 255 makes the sum overflow. A design that did not wrap the sum mod 256 would produce a wrong vector.
- A wrap event must not appear at reset. A design that treated reset as a wrap would raise bit 5 early.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int BIT_MATCH = 4;
  localparam int BIT_WRAP  = 5;
  localparam int BIT_VBL   = 6;
  localparam int BIT_TMR   = 7;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/line_timer.sv
module line_timer #(
  parameter int CYC_PER_LINE = 256,
  parameter int LINES        = 159,
  parameter int VIS_LINES    = 144,
  parameter int LW           = 8,
  parameter int DW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cmp_i,
  output logic [LW-1:0] line_o,
  output logic          ev_match_o,
  output logic          ev_wrap_o,
  output logic          ev_vbl_o
);
  localparam int CW = (CYC_PER_LINE > 1) ? $clog2(CYC_PER_LINE) : 1;
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYC_PER_LINE - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
  localparam logic [LW-1:0] LINE_VIS  = LW'(VIS_LINES);

  logic [CW-1:0] cyc_q;
  logic [LW-1:0] line_q, line_nxt;
  logic          line_end;

  assign line_end = (cyc_q == CYC_LAST);
  assign line_nxt = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else begin
      cyc_q <= line_end ? '0 : cyc_q + 1'b1;
      if (line_end) line_q <= line_nxt;
    end
  end

  // events are qualified by the edge that commits line_nxt
  assign ev_vbl_o   = line_end && (line_nxt == LINE_VIS);
  assign ev_wrap_o  = line_end && (line_nxt == '0);
  assign ev_match_o = line_end && (DW'(line_nxt) == cmp_i);
  assign line_o     = line_q;

  a_r2_line_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= LINE_LAST);
  a_r2_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_end) |-> line_q == $past(line_q));
  a_r3_vbl_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_vbl_o |=> line_q == LINE_VIS);
  a_r4_wrap_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wrap_o |=> line_q == '0);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] ev_i,
  output logic [DW-1:0] cmp_o,
  output logic [DW-1:0] stat_o,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] en_q, stat_q, base_q, cmp_q;
  logic [DW-1:0] clr_v, set_v, pend;
  logic [IW-1:0] idx;
  logic [DW-1:0] sum;

  assign clr_v = (wr_en_i && wr_sel_i == SEL_CLR) ? wr_data_i : '0;
  assign set_v = ev_i & en_q;

  genvar b;
  generate
    for (b = 0; b < DW; b++) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stat_q[b] <= 1'b0;
        else if (set_v[b]) stat_q[b] <= 1'b1;  // set beats clear
        else if (clr_v[b]) stat_q[b] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      base_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_CMP:  cmp_q  <= wr_data_i;
        SEL_EN:   en_q   <= wr_data_i;
        SEL_BASE: base_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  assign pend = stat_q & en_q;

  always_comb begin
    idx = '0;
    for (int i = 0; i < DW; i++)
      if (pend[i]) idx = IW'(i);
  end

  assign sum    = base_q + DW'(idx);
  assign irq_o  = |pend;
  assign vec_o  = irq_o ? {sum, 2'b00} : '0;
  assign stat_o = stat_q;
  assign cmp_o  = cmp_q;

  a_r7_set_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q)) & ~$past(en_q)) == '0);
  a_r8_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & $past(clr_v & ~ev_i)) == '0);
  a_r10_vec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);
  a_r9_irq_has_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $countones(stat_q & en_q) > 0);
endmodule

// File: rtl/line_irq_gen.sv
module line_irq_gen
  import line_irq_pkg::*;
#(
  parameter int CYC_PER_LINE = 256,
  parameter int LINES        = 159,
  parameter int VIS_LINES    = 144,
  parameter int LW           = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [7:0]    wr_data_i,
  input  logic          timer_req_i,
  output logic [LW-1:0] line_o,
  output logic [7:0]    stat_o,
  output logic          irq_o,
  output logic [9:0]    vec_o
);
  localparam int DW = 8;

  logic [DW-1:0] cmp, ev;
  logic ev_match, ev_wrap, ev_vbl;

  line_timer #(
    .CYC_PER_LINE(CYC_PER_LINE), .LINES(LINES), .VIS_LINES(VIS_LINES),
    .LW(LW), .DW(DW)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp), .line_o(line_o),
    .ev_match_o(ev_match), .ev_wrap_o(ev_wrap), .ev_vbl_o(ev_vbl)
  );

  always_comb begin
    ev            = '0;
    ev[BIT_MATCH] = ev_match;
    ev[BIT_WRAP]  = ev_wrap;
    ev[BIT_VBL]   = ev_vbl;
    ev[BIT_TMR]   = timer_req_i;
  end

  irq_ctrl #(.DW(DW)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ev_i(ev), .cmp_o(cmp), .stat_o(stat_o),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  a_r6_timer_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_req_i && u_irq.en_q[BIT_TMR]) |=> stat_o[BIT_TMR]);
endmodule

// File: tb/line_irq_gen_test.sv
module line_irq_gen_test;
  localparam int C = 8;
  localparam int L = 12;
  localparam int V = 9;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic we, tmr;
  logic [1:0] sel;
  logic [7:0] dat;
  logic [LW-1:0] line_o;
  logic [7:0] stat_o;
  logic irq_o;
  logic [9:0] vec_o;

  always #2.5 clk = ~clk;

  line_irq_gen #(.CYC_PER_LINE(C), .LINES(L), .VIS_LINES(V), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(dat),
    .timer_req_i(tmr), .line_o(line_o), .stat_o(stat_o), .irq_o(irq_o), .vec_o(vec_o)
  );

  int checks = 0, fails = 0;
  int n;
  logic [7:0] m_stat, m_en, m_cmp, m_base;
  int m_line;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at n=%0d", req, act, exp, n);
    end
  endtask

  function automatic int exp_vec(input logic [7:0] st, en, base);
    logic [7:0] p;
    int k;
    p = st & en;
    k = -1;
    for (int i = 0; i < 8; i++) if (p[i]) k = i;
    if (k < 0) return 0;
    return {8'(base + 8'(k)), 2'b00};
  endfunction

  // at a negedge: compare, drive, advance model across the next posedge
  task automatic step(input logic w, input logic [1:0] s, input logic [7:0] d,
                      input logic t);
    logic [7:0] ev, clr;
    chk("R2 line", int'(line_o), m_line);
    chk("R3/R4/R5/R6/R7/R8 stat", int'(stat_o), int'(m_stat));
    chk("R9 irq", int'(irq_o), int'((m_stat & m_en) != 0));
    chk("R10/R11 vec", int'(vec_o), exp_vec(m_stat, m_en, m_base));
    we = w; sel = s; dat = d; tmr = t;
    n++;
    ev = '0;
    if (n % C == 0) begin
      m_line = (n / C) % L;
      ev[6] = (m_line == V);
      ev[5] = (m_line == 0);
      ev[4] = (8'(m_line) == m_cmp);
    end
    ev[7] = t;
    clr = (w && s == 2'd2) ? d : 8'h00;
    m_stat = (m_stat & ~clr) | (ev & m_en);
    if (w) case (s)
      2'd0: m_cmp = d;
      2'd1: m_en = d;
      2'd3: m_base = d;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b0, 2'd0, 8'h00, 1'b0);
  endtask

  initial begin
    #750000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; sel = 2'd0; dat = 8'h00; tmr = 1'b0;
    n = 0; m_line = 0; m_stat = 0; m_en = 0; m_cmp = 0; m_base = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 line", int'(line_o), 0);
    chk("R1 stat", int'(stat_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    rst_n = 1'b1;

    // R2 / R7: two frames with everything disabled, timer pulsing
    for (int i = 0; i < 2 * C * L; i++) step(1'b0, 2'd0, 8'h00, (i % 5) == 0);

    // R5 / R3 / R4: compare sweep over every line, frame and wrap enabled
    step(1'b1, 2'd3, 8'h3C, 1'b0);
    step(1'b1, 2'd1, 8'h70, 1'b0);
    for (int c = 0; c < L; c++) begin
      step(1'b1, 2'd0, 8'(c), 1'b0);
      idle(C * L - 2);
      step(1'b1, 2'd2, 8'hFF, 1'b0);
    end
    // R5: compare written equal to the current line does not fire
    begin
      int mid;
      mid = m_line;
      step(1'b1, 2'd1, 8'h10, 1'b0);
      step(1'b1, 2'd0, 8'(mid), 1'b0);
      idle(C - 3);
      chk("R5 no fire on write", int'(stat_o[4]), 0);
    end

    // R6 / R8 / R9 / R10: mixed traffic, base wraps past 255
    step(1'b1, 2'd3, 8'hFE, 1'b0);
    step(1'b1, 2'd0, 8'd3, 1'b0);
    step(1'b1, 2'd1, 8'hF0, 1'b0);
    for (int i = 0; i < 4 * C * L; i++) begin
      if (i % 7 == 3)        step(1'b1, 2'd2, 8'h80 >> (i % 4), (i % 13) == 0);
      else if (i % 53 == 20) step(1'b1, 2'd1, ((i / 53) % 2) ? 8'hF0 : 8'h50, 1'b0);
      else                   step(1'b0, 2'd0, 8'h00, (i % 13) == 0);
    end

    // R8: set wins over clear at the same edge
    step(1'b1, 2'd1, 8'h80, 1'b0);
    step(1'b1, 2'd2, 8'hFF, 1'b0);
    step(1'b1, 2'd2, 8'h80, 1'b1);
    chk("R8 set wins", int'(stat_o[7]), 1);
    chk("R10 vec wrap", int'(vec_o), {8'(8'hFE + 8'd7), 2'b00});
    // R9: masking keeps status but drops request
    step(1'b1, 2'd1, 8'h00, 1'b0);
    chk("R9 masked irq", int'(irq_o), 0);
    chk("R9 status kept", int'(stat_o[7]), 1);
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule